// File: doc/BRIEF.md
# Loop Counter Branch Evaluator

This block evaluates one counted-loop branch instruction per strobe. It takes a packed control byte, an 8-bit offset byte, the address of the instruction, and the value read from the register the control byte names. It returns four things: the stepped register value with a write enable, a taken flag, the next fetch address, and an illegal flag. All results appear on registered outputs one clock after the strobe.

The control byte carries several fields. Bits 7:6 pick the step: 00 counts down, 01 only tests, 10 counts up, and 11 is illegal. Bit 5 picks the condition: 1 branches when the stepped value is zero, 0 branches when it is nonzero. Bit 4 is the sign of a 9-bit displacement whose lower eight bits are the offset byte. Bits 2:0 name the register, with codes 0 and 1 for the byte-wide accumulators and codes 4 to 7 for the word-wide registers. Codes 2 and 3 are not usable.

The instruction is three bytes long. The branch target is therefore the instruction address plus 3 plus the sign-extended displacement. The register file and instruction fetch sit outside the block. The read selector is presented combinationally so that the file can return the operand in the same cycle.

Top module: `loop_branch_unit`

## Requirements
- R1: With valid_i high and postbyte bits 7:6 = 00, the result is the operand minus one (wrapping), with wr_en_o = 1.
- R2: With bits 7:6 = 10, the result is the operand plus one (wrapping), with wr_en_o = 1.
- R3: With bits 7:6 = 01, wr_en_o = 0, and the condition is tested on the unmodified operand.
- R4: With bit 5 = 1, taken_o = 1 exactly when the result is zero. With bit 5 = 0, taken_o = 1 exactly when it is nonzero.
- R5: Selector codes 0 and 1 work at 8 bits. Only rd_data_i[7:0] is used, the step wraps at 8 bits, the zero test covers 8 bits, and wr_data_o[15:8] = 0. Codes 4 to 7 work on all 16 bits.
- R6: When taken, next_pc_o = pc_i + 3 + sign-extended {postbyte bit 4, offset_i}, modulo 2^16.
- R7: When not taken, next_pc_o = pc_i + 3.
- R8: Bits 7:6 = 11 or selector code 2 or 3 set illegal_o = 1, force wr_en_o = 0 and taken_o = 0, and give next_pc_o = pc_i + 3.
- R9: done_o pulses one cycle after each valid_i cycle. wr_en_o, taken_o and illegal_o are 0 whenever done_o is 0.
- R10: While rst_ni is low, all registered outputs are zero.
- R11: rd_sel_o equals postbyte bits 2:0 combinationally, and wr_sel_o registers that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Evaluate the presented instruction |
| postbyte_i | input | 8 | Packed loop control byte |
| offset_i | input | 8 | Low eight bits of the displacement |
| pc_i | input | 16 | Address of the instruction |
| rd_sel_o | output | 3 | Register read selector |
| rd_data_i | input | 16 | Operand returned for rd_sel_o |
| done_o | output | 1 | Result valid pulse |
| wr_en_o | output | 1 | Register write enable |
| wr_sel_o | output | 3 | Register write selector |
| wr_data_o | output | 16 | Stepped register value |
| taken_o | output | 1 | Branch taken |
| illegal_o | output | 1 | Unusable encoding |
| next_pc_o | output | 16 | Next fetch address |

## Verification
The hardest cases to reach are the 8-bit corners. A stale upper byte must not hide a zero result, and a byte-wide step must wrap without a carry leaking into bit 8. The sweep reaches these by driving operands such as 0x0100, 0xFF01 and 0x12FF through every one of the 256 control bytes. The same sweep covers offsets at both extremes of the 9-bit range, so the target adder's wraparound at address 0xFFFx is also exercised.

// File: rtl/loop_pkg.sv
package loop_pkg;
  typedef enum logic [1:0] {
    STEP_DOWN = 2'b00,
    STEP_NONE = 2'b01,
    STEP_UP   = 2'b10,
    STEP_BAD  = 2'b11
  } step_e;

  typedef struct packed {
    step_e      step;
    logic       on_zero;
    logic       disp_sign;
    logic [2:0] sel;
    logic       narrow;
    logic       illegal;
    logic       writes;
  } loop_ctl_t;
endpackage

// File: rtl/loop_decode.sv
module loop_decode
  import loop_pkg::*;
(
  input  logic [7:0] pb_i,
  output loop_ctl_t  ctl_o
);
  localparam int STEP_HI = 7;
  localparam int STEP_LO = 6;
  localparam int COND_B  = 5;
  localparam int SIGN_B  = 4;

  logic bad_sel;
  always_comb begin
    ctl_o.step      = step_e'(pb_i[STEP_HI:STEP_LO]);
    ctl_o.on_zero   = pb_i[COND_B];
    ctl_o.disp_sign = pb_i[SIGN_B];
    ctl_o.sel       = pb_i[2:0];
    ctl_o.narrow    = (pb_i[2:1] == 2'b00);
    bad_sel         = (pb_i[2:1] == 2'b01);
    ctl_o.illegal   = bad_sel || (ctl_o.step == STEP_BAD);
    ctl_o.writes    = !ctl_o.illegal && (ctl_o.step != STEP_NONE);
  end
endmodule

// File: rtl/loop_count.sv
module loop_count
  import loop_pkg::*;
#(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  loop_ctl_t        ctl_i,
  input  logic [DW-1:0]    opnd_i,
  output logic [DW-1:0]    res_o,
  output logic             zero_o
);
  localparam int UW = DW - BW;

  logic [DW-1:0] wide_res;
  logic [BW-1:0] byte_res;

  always_comb begin
    unique case (ctl_i.step)
      STEP_DOWN: begin
        wide_res = opnd_i - DW'(1);
        byte_res = opnd_i[BW-1:0] - BW'(1);
      end
      STEP_UP: begin
        wide_res = opnd_i + DW'(1);
        byte_res = opnd_i[BW-1:0] + BW'(1);
      end
      default: begin
        wide_res = opnd_i;
        byte_res = opnd_i[BW-1:0];
      end
    endcase
  end

  generate
    if (UW > 0) begin : g_split
      assign res_o = ctl_i.narrow ? {{UW{1'b0}}, byte_res} : wide_res;
    end else begin : g_flat
      assign res_o = wide_res;
    end
  endgenerate

  assign zero_o = (res_o == '0);
endmodule

// File: rtl/loop_target.sv
module loop_target #(
  parameter int AW   = 16,
  parameter int BW   = 8,
  parameter int ILEN = 3
) (
  input  logic [AW-1:0] pc_i,
  input  logic          sign_i,
  input  logic [BW-1:0] off_i,
  output logic [AW-1:0] seq_o,
  output logic [AW-1:0] tgt_o
);
  localparam int XW = AW - BW - 1;
  logic [AW-1:0] disp;
  assign disp  = {{XW{sign_i}}, sign_i, off_i};
  assign seq_o = pc_i + AW'(ILEN);
  assign tgt_o = seq_o + disp;
endmodule

// File: rtl/loop_branch_unit.sv
module loop_branch_unit
  import loop_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int BW   = 8,
  parameter int ILEN = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [7:0]    postbyte_i,
  input  logic [BW-1:0] offset_i,
  input  logic [AW-1:0] pc_i,
  output logic [2:0]    rd_sel_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          done_o,
  output logic          wr_en_o,
  output logic [2:0]    wr_sel_o,
  output logic [DW-1:0] wr_data_o,
  output logic          taken_o,
  output logic          illegal_o,
  output logic [AW-1:0] next_pc_o
);
  loop_ctl_t     ctl;
  logic [DW-1:0] res;
  logic          res_zero;
  logic [AW-1:0] seq_pc, tgt_pc;
  logic          take;

  loop_decode u_dec (.pb_i(postbyte_i), .ctl_o(ctl));

  loop_count #(.DW(DW), .BW(BW)) u_cnt (
    .ctl_i(ctl), .opnd_i(rd_data_i), .res_o(res), .zero_o(res_zero)
  );

  loop_target #(.AW(AW), .BW(BW), .ILEN(ILEN)) u_tgt (
    .pc_i(pc_i), .sign_i(ctl.disp_sign), .off_i(offset_i),
    .seq_o(seq_pc), .tgt_o(tgt_pc)
  );

  assign rd_sel_o = ctl.sel;
  assign take     = !ctl.illegal && (ctl.on_zero == res_zero);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_sel_o  <= '0;
      wr_data_o <= '0;
      taken_o   <= 1'b0;
      illegal_o <= 1'b0;
      next_pc_o <= '0;
    end else begin
      done_o    <= valid_i;
      wr_en_o   <= valid_i && ctl.writes;
      taken_o   <= valid_i && take;
      illegal_o <= valid_i && ctl.illegal;
      if (valid_i) begin
        wr_sel_o  <= ctl.sel;
        wr_data_o <= res;
        next_pc_o <= take ? tgt_pc : seq_pc;
      end
    end
  end

  p_side_needs_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o || taken_o || illegal_o) |-> done_o);
  p_illegal_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!wr_en_o && !taken_o));
  p_fallthrough_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !take) |=> (next_pc_o == $past(pc_i) + AW'(ILEN)));
  p_test_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && postbyte_i[7:6] == 2'b01) |=> !wr_en_o);
  p_narrow_upper_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_sel_o[2:1] == 2'b00) |-> (wr_data_o[DW-1:BW] == '0));
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
endmodule

// File: tb/loop_branch_unit_test.sv
module loop_branch_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  pb = '0;
  logic [7:0]  off = '0;
  logic [15:0] pc = '0;
  logic [15:0] rdata = '0;
  logic [2:0]  rd_sel, wr_sel;
  logic        done, wr_en, taken, illegal;
  logic [15:0] wr_data, next_pc;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  loop_branch_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .postbyte_i(pb),
    .offset_i(off), .pc_i(pc), .rd_sel_o(rd_sel), .rd_data_i(rdata),
    .done_o(done), .wr_en_o(wr_en), .wr_sel_o(wr_sel), .wr_data_o(wr_data),
    .taken_o(taken), .illegal_o(illegal), .next_pc_o(next_pc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [15:0] data_set [8] = '{16'h0000, 16'h0001, 16'h00FF, 16'h0100,
                                16'hFFFF, 16'h8000, 16'h12FF, 16'hFF01};
  logic [7:0]  off_set [5]  = '{8'h00, 8'h7F, 8'h80, 8'hFF, 8'h05};
  logic [15:0] pc_set [3]   = '{16'h1000, 16'hFFFE, 16'h0002};

  initial begin
    #1000000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0]  op;
    logic        narrow, ill, zero, e_take, e_wr;
    logic [15:0] val, nv, disp, e_pc;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 done", done, 0);
    check("R10 wr_en", wr_en, 0);
    check("R10 taken", taken, 0);
    check("R10 next_pc", next_pc, 0);
    check("R10 wr_data", wr_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle done", done, 0);
    for (int p = 0; p < 256; p++) begin
      for (int d = 0; d < 8; d++) begin
        for (int o = 0; o < 5; o++) begin
          pb = 8'(p); rdata = data_set[d]; off = off_set[o];
          pc = pc_set[(p + d + o) % 3]; valid = 1'b1;
          #0;
          check("R11 rd_sel", rd_sel, pb[2:0]);
          op = pb[7:6];
          narrow = (pb[2:0] < 3'd2);
          ill = (op == 2'b11) || (pb[2:0] == 3'd2) || (pb[2:0] == 3'd3);
          val = narrow ? {8'h00, rdata[7:0]} : rdata;
          nv = (op == 2'b00) ? val - 16'd1 : (op == 2'b10) ? val + 16'd1 : val;
          if (narrow) nv = {8'h00, nv[7:0]};
          zero = (nv == 16'h0);
          e_take = !ill && (pb[5] ? zero : !zero);
          e_wr = !ill && (op != 2'b01);
          disp = {{7{pb[4]}}, pb[4], off};
          e_pc = e_take ? pc + 16'd3 + disp : pc + 16'd3;
          @(negedge clk);
          check("R9 done", done, 1);
          check("R8 illegal", illegal, ill);
          if (op == 2'b01) check("R3 test write", wr_en, 0);
          else check("R1 R2 wr_en", wr_en, e_wr);
          check("R4 taken", taken, e_take);
          if (e_take) check("R6 target", next_pc, e_pc);
          else check("R7 fallthrough", next_pc, e_pc);
          check("R11 wr_sel", wr_sel, pb[2:0]);
          if (e_wr) begin
            if (narrow) check("R5 narrow data", wr_data, nv);
            else if (op == 2'b00) check("R1 dec data", wr_data, nv);
            else check("R2 inc data", wr_data, nv);
          end
        end
      end
    end
    valid = 1'b0;
    @(negedge clk);
    check("R9 quiet done", done, 0);
    check("R9 quiet wr_en", wr_en, 0);
    check("R9 quiet taken", taken, 0);
    check("R9 quiet illegal", illegal, 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule